// File: doc/BRIEF.md
# Programmable Interval Timer With Register Bus

This block is a memory-mapped down-counting timer with a plain register bus: address, write data, write enable and a combinational read-data return. Software writes a 64-bit load value as two 32-bit words, chooses a mode and starts the timer through a control register. The timer then raises a sticky pending flag at each expiry. In periodic mode the counter reloads and keeps firing. In one-shot mode it fires a single time. The interrupt line is the pending flag gated by a mask bit, and software acknowledges an expiry by writing a one to the status register.

Two register-map variants exist that differ only in where the control register sits. A parameter picks the variant at build time. Everything runs on one clock, and each clock is one timer tick.

Top module: `prog_timer`

## Requirements
- R1: After reset every readable register returns 0 and `irqOut` is low.
- R2: The load word at offset 0x00 holds bits 31:0 and the word at offset 0x04 holds bits 63:32 of the load value. Both read back as written. Reads from any offset that has no register return 0, and this includes the control offset of the variant that is not selected.
- R3: With `CTRL_ALT`=0 the control register is at offset 0x10, and with `CTRL_ALT`=1 it is at 0x1C. Bit 0 is enable, bit 1 is mode (0 = periodic, 1 = one-shot) and bit 2 is interrupt unmask. A read returns these three bits, and all upper bits read as 0.
- R4: A control write that sets enable while the timer is disabled loads the counter from the load value N. In periodic mode the first expiry happens N+1 clocks after that write, and a further expiry follows every N+1 clocks. The load value in force at each expiry is the one reloaded.
- R5: In one-shot mode exactly one expiry happens, N+1 clocks after the enabling write. No further expiry happens until the timer is disabled and then enabled again.
- R6: The status register at offset 0x18 reads 1 in bit 0 after an expiry. Writing 1 to bit 0 clears it, and writing 0 to bit 0 leaves it unchanged. If an expiry and a clearing write fall on the same clock, the status ends up set.
- R7: Every expiry sets the status whatever the mask is. `irqOut` is high exactly when the status bit and the unmask bit are both 1.
- R8: Writing 0 to the control register stops the timer, and no expiry happens while enable is 0. Writing enable=1 while the timer is already enabled does not restart the count.
- R9: The counter is the full 64 bits wide. A load value with a nonzero upper word does not expire after the number of clocks that its lower word alone would take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset of the register being accessed |
| busWdata | input | DATA_W | Write data |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busRdata | output | DATA_W | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Interrupt request, pending and unmasked |

## Verification
The bench goes after a load value of zero, which must expire on every clock. A counter that is off by one would skip beats or fire one clock late, and the bench would see the status at the wrong time. A clearing write that lands on the same clock as an expiry must leave the status set, so a design that lets the clear win would lose events. A one-shot timer must stay silent after its single event, and a design that reloads it would fire again. A repeated enable while the timer is running must not restart the count, and a design that restarts it would shift the period. A load value with a nonzero upper word must stay quiet, and a design whose counter is only 32 bits wide would fire early.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Strobes from the register side to the counting datapath.
  typedef struct packed {
    logic start;    // enable goes from 0 to 1 on this clock
    logic run;      // enable bit as currently stored
    logic oneShot;  // mode bit: 1 = single expiry
  } tmrStrobe_t;

  // Control bit positions, which the bus decodes.
  localparam int CTL_EN     = 0;
  localparam int CTL_MODE   = 1;
  localparam int CTL_UNMASK = 2;
  localparam int CTL_BITS   = 3;

  // Register offsets.
  localparam int OFF_STATUS = 'h18;
  localparam int OFF_CTRL_A = 'h10;
  localparam int OFF_CTRL_B = 'h1C;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 64,
  parameter bit CTRL_ALT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              expire,
  output logic [DATA_W-1:0] busRdata,
  output logic [CNT_W-1:0]  loadVal,
  output tmrStrobe_t        strobe,
  output logic              statusBit,
  output logic              unmaskBit,
  output logic              irqOut
);

  localparam int LOAD_WORDS = CNT_W / DATA_W;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(OFF_STATUS);

  logic [ADDR_W-1:0]   ctrlAddr;
  logic [CTL_BITS-1:0] ctrlReg;
  logic [CNT_W-1:0]    loadReg;
  logic                ctrlWrite;
  logic                statWrite;

  // The register-map variant decides where the control register is decoded.
  generate
    if (CTRL_ALT) begin : g_ctrl_alt
      assign ctrlAddr = ADDR_W'(OFF_CTRL_B);
    end else begin : g_ctrl_base
      assign ctrlAddr = ADDR_W'(OFF_CTRL_A);
    end
  endgenerate

  assign ctrlWrite = busWe && (busAddr == ctrlAddr);
  assign statWrite = busWe && (busAddr == STAT_ADDR);

  // The load words sit at consecutive word offsets, starting at zero.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadReg <= '0;
    end else if (busWe) begin
      for (int w = 0; w < LOAD_WORDS; w++) begin
        if (busAddr == ADDR_W'(w * WORD_BYTES)) begin
          loadReg[w*DATA_W +: DATA_W] <= busWdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (ctrlWrite) begin
      ctrlReg <= busWdata[CTL_BITS-1:0];
    end
  end

  // An expiry sets the status and wins over a clearing write on the same clock.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusBit <= 1'b0;
    end else if (expire) begin
      statusBit <= 1'b1;
    end else if (statWrite && busWdata[0]) begin
      statusBit <= 1'b0;
    end
  end

  assign strobe.start   = ctrlWrite && busWdata[CTL_EN] && !ctrlReg[CTL_EN];
  assign strobe.run     = ctrlReg[CTL_EN];
  assign strobe.oneShot = ctrlReg[CTL_MODE];

  assign loadVal   = loadReg;
  assign unmaskBit = ctrlReg[CTL_UNMASK];
  assign irqOut    = statusBit && unmaskBit;

  always_comb begin
    busRdata = '0;
    for (int w = 0; w < LOAD_WORDS; w++) begin
      if (busAddr == ADDR_W'(w * WORD_BYTES)) begin
        busRdata = loadReg[w*DATA_W +: DATA_W];
      end
    end
    if (busAddr == ctrlAddr) begin
      busRdata = DATA_W'(ctrlReg);
    end
    if (busAddr == STAT_ADDR) begin
      busRdata = DATA_W'(statusBit);
    end
  end

endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  output logic             expire,
  output logic [CNT_W-1:0] count
);

  logic armed;

  // The count from N down to zero spans N+1 clocks, and zero is the expiry.
  assign expire = armed && strobe.run && (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      armed <= 1'b0;
    end else if (strobe.start) begin
      count <= loadVal;
      armed <= 1'b1;
    end else if (!strobe.run) begin
      armed <= 1'b0;
    end else if (expire) begin
      if (strobe.oneShot) begin
        armed <= 1'b0;
      end else begin
        count <= loadVal;
      end
    end else if (armed) begin
      count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/prog_timer.sv
module prog_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 64,
  parameter bit CTRL_ALT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);

  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] count;
  logic             expire;
  logic             statusBit;
  logic             unmaskBit;

  tmr_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .CTRL_ALT(CTRL_ALT)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busWe    (busWe),
    .expire   (expire),
    .busRdata (busRdata),
    .loadVal  (loadVal),
    .strobe   (strobe),
    .statusBit(statusBit),
    .unmaskBit(unmaskBit),
    .irqOut   (irqOut)
  );

  tmr_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .loadVal(loadVal),
    .expire (expire),
    .count  (count)
  );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 64,
  parameter bit CTRL_ALT = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              wrBit0,
  input logic              irqOut,
  input tmrStrobe_t        strobe,
  input logic              expire,
  input logic              statusBit,
  input logic              unmaskBit,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  loadVal
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = CTRL_ALT ? ADDR_W'(OFF_CTRL_B) : ADDR_W'(OFF_CTRL_A);

  logic clrWrite;
  logic ctrlWrite;
  assign clrWrite  = busWe && (busAddr == STAT_ADDR) && wrBit0;
  assign ctrlWrite = busWe && (busAddr == CTRL_ADDR);

  // R4: a periodic expiry reloads the counter with the load value of that clock
  a_r4_reload: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !strobe.oneShot) |=> (count == $past(loadVal)));

  // R5: a one-shot expiry is not followed by another without a restart
  a_r5_single_shot: assert property (@(posedge clk) disable iff (!rstN)
    (expire && strobe.oneShot && !strobe.start) |=> !expire);

  // R6: an expiry leaves the status set, even against a clearing write
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> statusBit);

  // R6: a clearing write without an expiry drops the status
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && !expire) |=> !statusBit);

  // R7: an unmasked expiry raises the interrupt on the next clock
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    (expire && unmaskBit && !ctrlWrite) |=> irqOut);

  // R8: a disabled timer with no start pending does not expire
  a_r8_stopped_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.start) |=> !expire);

endmodule

bind prog_timer tmr_checker #(
  .ADDR_W  (ADDR_W),
  .CNT_W   (CNT_W),
  .CTRL_ALT(CTRL_ALT)
) u_tmr_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .wrBit0   (busWdata[0]),
  .irqOut   (irqOut),
  .strobe   (strobe),
  .expire   (expire),
  .statusBit(statusBit),
  .unmaskBit(unmaskBit),
  .count    (count),
  .loadVal  (loadVal)
);

// File: tb/test_prog_timer.sv
`timescale 1ns/1ps
module test_prog_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut;

  always #10 clk = ~clk;

  prog_timer #(.CTRL_ALT(1'b0)) i_prog_timer (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busWe   (busWe),
    .busRdata(busRdata),
    .irqOut  (irqOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Model state, taken from the requirements
  logic [31:0] mLo = '0, mHi = '0;
  logic        mEn = 0, mMode = 0, mUnm = 0, mStat = 0, mArmed = 0;
  logic [63:0] mN = '0, mEl = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    check(tag, busRdata, exp);
  endtask

  // One clock with an optional write; the model advances and status and irq are checked.
  task automatic step(input string tag, input logic we, input logic [7:0] a, input logic [31:0] d);
    logic ex;
    busWe = we; busAddr = a; busWdata = d;
    @(posedge clk);
    ex = mArmed && mEn && (mEl == mN);
    if (ex) begin
      if (mMode) mArmed = 1'b0;
      else begin mEl = '0; mN = {mHi, mLo}; end
    end else if (mArmed && mEn) begin
      mEl = mEl + 1;
    end
    if (ex) mStat = 1'b1;
    else if (we && a == 8'h18 && d[0]) mStat = 1'b0;
    if (we && a == 8'h10) begin
      if (d[0] && !mEn) begin mArmed = 1'b1; mEl = '0; mN = {mHi, mLo}; end
      if (!d[0]) mArmed = 1'b0;
      mEn = d[0]; mMode = d[1]; mUnm = d[2];
    end
    if (we && a == 8'h00) mLo = d;
    if (we && a == 8'h04) mHi = d;
    #1;
    busWe = 1'b0;
    busAddr = 8'h18;
    #1;
    check({tag, " status"}, busRdata, {31'b0, mStat});
    check({tag, " irq"}, {31'b0, irqOut}, {31'b0, mStat & mUnm});
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 8'h18, 32'h0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;

    // R1: reset state
    rd("R1 load lo", 8'h00, 32'h0);
    rd("R1 load hi", 8'h04, 32'h0);
    rd("R1 ctrl", 8'h10, 32'h0);
    rd("R1 status", 8'h18, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    // R2: load words and unmapped offsets
    step("R2", 1'b1, 8'h00, 32'hDEAD_BEEF);
    step("R2", 1'b1, 8'h04, 32'h1234_5678);
    rd("R2 lo readback", 8'h00, 32'hDEAD_BEEF);
    rd("R2 hi readback", 8'h04, 32'h1234_5678);
    rd("R2 unmapped 08", 8'h08, 32'h0);
    rd("R2 unmapped 14", 8'h14, 32'h0);
    rd("R2 other ctrl offset 1C", 8'h1C, 32'h0);
    rd("R2 unmapped 20", 8'h20, 32'h0);
    step("R2", 1'b1, 8'h04, 32'h0);

    // R3: control layout, upper bits read zero (enable left clear)
    step("R3", 1'b1, 8'h10, 32'hFFFF_FFF6);
    rd("R3 ctrl readback", 8'h10, 32'h0000_0006);
    step("R3", 1'b1, 8'h10, 32'h0);
    rd("R3 ctrl cleared", 8'h10, 32'h0);

    // R4: periodic, N = 3, unmasked
    step("R4", 1'b1, 8'h00, 32'd3);
    step("R4", 1'b1, 8'h10, 32'h5);
    idle("R4", 3);
    step("R4", 1'b0, 8'h18, 32'h0);
    check("R4 first expiry after N+1", busRdata, 32'h1);
    step("R4", 1'b1, 8'h18, 32'h1);
    idle("R4", 2);
    step("R4", 1'b0, 8'h18, 32'h0);
    check("R4 second expiry", busRdata, 32'h1);
    step("R4", 1'b1, 8'h00, 32'd5);
    idle("R4", 14);

    // R6: writing 0 keeps the status, writing 1 clears it, set wins when simultaneous
    step("R6", 1'b1, 8'h10, 32'h0);
    idle("R6", 2);
    step("R6", 1'b1, 8'h18, 32'h0);
    step("R6", 1'b1, 8'h18, 32'h1);
    step("R6", 1'b1, 8'h00, 32'd0);
    step("R6", 1'b1, 8'h10, 32'h5);
    step("R6", 1'b0, 8'h18, 32'h0);
    step("R6", 1'b1, 8'h18, 32'h1);
    check("R6 set wins over clear", busRdata, 32'h1);
    idle("R6", 3);

    // R7: masked expiry still sets status; unmask raises irq; re-enable does not restart (R8)
    step("R7", 1'b1, 8'h10, 32'h0);
    step("R7", 1'b1, 8'h18, 32'h1);
    step("R7", 1'b1, 8'h00, 32'd2);
    step("R7", 1'b1, 8'h10, 32'h1);
    idle("R7", 8);
    step("R7", 1'b1, 8'h10, 32'h5);
    idle("R7", 2);
    step("R8", 1'b1, 8'h18, 32'h1);
    step("R8", 1'b1, 8'h10, 32'h5);
    idle("R8", 6);

    // R8: stop by writing zero
    step("R8", 1'b1, 8'h10, 32'h0);
    step("R8", 1'b1, 8'h18, 32'h1);
    idle("R8", 20);

    // R5: one-shot, N = 4, then a second shot after a restart
    step("R5", 1'b1, 8'h00, 32'd4);
    step("R5", 1'b1, 8'h10, 32'h7);
    idle("R5", 4);
    step("R5", 1'b0, 8'h18, 32'h0);
    check("R5 single expiry at N+1", busRdata, 32'h1);
    step("R5", 1'b1, 8'h18, 32'h1);
    idle("R5", 25);
    step("R5", 1'b1, 8'h10, 32'h0);
    step("R5", 1'b1, 8'h10, 32'h7);
    idle("R5", 12);

    // R9: nonzero upper word must not expire on the lower word alone
    step("R9", 1'b1, 8'h10, 32'h0);
    step("R9", 1'b1, 8'h18, 32'h1);
    step("R9", 1'b1, 8'h00, 32'd2);
    step("R9", 1'b1, 8'h04, 32'd1);
    step("R9", 1'b1, 8'h10, 32'h7);
    idle("R9", 300);
    step("R9", 1'b1, 8'h10, 32'h0);
    step("R9", 1'b1, 8'h04, 32'd0);

    // Random mix across modes, masks, clears and reloads (R4, R5, R6, R7)
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 10)       step("R4/R5 random", 1'b0, 8'h18, 32'h0);
      else if (r < 12)  step("R5/R8 random", 1'b1, 8'h10, {29'b0, 3'($urandom)});
      else if (r < 14)  step("R6 random", 1'b1, 8'h18, {31'b0, 1'($urandom)});
      else if (r == 14) step("R4 random", 1'b1, 8'h00, $urandom % 6);
      else              step("R7 random", 1'b1, 8'h10, {29'b0, 3'($urandom) | 3'b001});
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule